// File: doc/BRIEF.md
# Receive FIFO Threshold Interrupt Controller

This block sits between a serial receive shifter and a processor read port. Each word the shifter completes is stored in a first-in first-out buffer. The processor drains the buffer through a read strobe, and the popped word appears on the read-data output in the next cycle. A receive-data-full flag tells software that a batch is ready. It rises in either of two cases. The first is when the number of stored words equals a programmed threshold. The second is when the line has stayed quiet for longer than a fixed number of baud ticks while some words, fewer than the threshold, are waiting.

The full flag stays up until a read empties the buffer. A word that arrives while the buffer already holds its full capacity is thrown away, the stored words are kept, and a sticky overrun flag is raised. Only an error-clear strobe drops the overrun flag. A registered interrupt request combines both flags with an interrupt enable. The idle timer runs only while the buffer-enable and idle-detect-enable inputs are both high.

Top module: `rx_fifo_irq_ctrl`

## Requirements
- R1: A received-word strobe while `count` < DEPTH stores the word and raises `count` by one at the next edge. Reads return words in arrival order, and the popped word appears on `rd_data` one cycle after `rd_stb`.
- R2: A read of a non-empty buffer in the same cycle as an accepted word leaves `count` unchanged. The stored order stays intact.
- R3: With a non-zero `threshold`, `full_flag` rises one cycle after `count` equals `threshold`. A threshold of 0 never sets the flag.
- R4: The idle timer is armed when `idle_en` and `fifo_en` are high, 0 < `count`, `full_flag` is low, and either `threshold` is 0 or `count` < `threshold`. While it is armed and undisturbed, the (IDLE_TICKS+1)th `baud_tick` sets `full_flag` at the next edge.
- R5: Any `rd_stb` or `word_valid` resets the idle tick count to zero, and counting then starts again.
- R6: While `fifo_en` is low, the idle count is held at zero. Raising `fifo_en` again with data still stored starts a fresh count.
- R7: `full_flag` clears only on the edge where a read takes the last stored word and no word arrives in the same cycle.
- R8: A `word_valid` while `count` equals DEPTH sets `ovr_flag`. That word is discarded and the stored words are unchanged.
- R9: `ovr_flag` stays set until `err_clr`. A new overrun in the same cycle as `err_clr` wins.
- R10: `irq` is a register loaded each cycle with `irq_en` AND (next `full_flag` OR next `ovr_flag`).
- R11: `rd_stb` on an empty buffer is ignored: `count` stays 0 and `rd_data` keeps its value.
- R12: After synchronous reset, `count`, `rd_data`, `full_flag`, `ovr_flag` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Received-word strobe from the shifter |
| word_data | input | DATA_W | Received word |
| rd_stb | input | 1 | Processor read strobe |
| fifo_en | input | 1 | Buffer enable; gates the idle timer |
| idle_en | input | 1 | Idle-timeout detection enable |
| irq_en | input | 1 | Receive interrupt enable |
| threshold | input | CNT_W | Word count that sets the full flag (0 = off) |
| baud_tick | input | 1 | One pulse per baud clock |
| err_clr | input | 1 | Clears the overrun flag |
| rd_data | output | DATA_W | Word popped by the last read |
| count | output | CNT_W | Number of stored words |
| full_flag | output | 1 | Receive-data-full flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with DEPTH=8, IDLE_TICKS=3 and 9-bit words. These values make the full buffer, the overrun discard and the idle timeout reachable within tens of cycles, so each one is exercised many times. Threshold values span 0 through DEPTH, which covers the disabled threshold, the threshold that equals capacity and the cases where the idle path competes with the threshold path. The random phase mixes arrivals, reads, ticks and enable toggles, so same-cycle read and arrival, reads during the idle count, and overrun with a simultaneous clear all occur.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef struct packed {
    logic push;     // word accepted into storage
    logic pop;      // word removed by processor
    logic ovr_hit;  // word arrived with storage at capacity
  } rx_evt_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int IDLE_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic activity,
  input  logic baud_tick,
  output logic hit
);
  localparam int TW = $clog2(IDLE_TICKS + 1);
  localparam logic [TW-1:0] LIMIT = TW'(IDLE_TICKS);

  logic [TW-1:0] ticks;
  logic          restart;

  assign restart = activity || !armed;
  assign hit     = !restart && baud_tick && (ticks == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart)  ticks <= '0;
    else if (baud_tick)  ticks <= (ticks == LIMIT) ? '0 : ticks + 1'b1;
  end
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  rx_evt_t          evt,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] threshold,
  input  logic             idle_hit,
  input  logic             err_clr,
  input  logic             irq_en,
  output logic             full_flag,
  output logic             ovr_flag,
  output logic             irq
);
  logic drained, thr_hit, full_d, ovr_d;

  assign drained = evt.pop && !evt.push && (count == CNT_W'(1));
  assign thr_hit = (threshold != '0) && (count == threshold);
  assign full_d  = drained ? 1'b0 : (full_flag || thr_hit || idle_hit);
  assign ovr_d   = evt.ovr_hit ? 1'b1 : (err_clr ? 1'b0 : ovr_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_flag <= 1'b0;
      ovr_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      full_flag <= full_d;
      ovr_flag  <= ovr_d;
      irq       <= irq_en && (full_d || ovr_d);
    end
  end
endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int DEPTH      = 64,
  parameter int IDLE_TICKS = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              rd_stb,
  input  logic              fifo_en,
  input  logic              idle_en,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              baud_tick,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  rx_evt_t evt;
  logic    at_cap, empty, idle_armed, idle_hit;

  assign at_cap      = (count == CAP);
  assign empty       = (count == '0);
  assign evt.push    = word_valid && !at_cap;
  assign evt.pop     = rd_stb && !empty;
  assign evt.ovr_hit = word_valid && at_cap;

  assign idle_armed = idle_en && fifo_en && !empty && !full_flag &&
                      ((threshold == '0) || (count < threshold));

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .push    (evt.push),
    .pop     (evt.pop),
    .wr_data (word_data),
    .rd_data (rd_data),
    .count   (count)
  );

  rx_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .armed     (idle_armed),
    .activity  (word_valid || rd_stb),
    .baud_tick (baud_tick),
    .hit       (idle_hit)
  );

  rx_flag_ctrl #(.CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .count     (count),
    .threshold (threshold),
    .idle_hit  (idle_hit),
    .err_clr   (err_clr),
    .irq_en    (irq_en),
    .full_flag (full_flag),
    .ovr_flag  (ovr_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/rx_fifo_irq_checker.sv
module rx_fifo_irq_checker #(
  parameter int DATA_W     = 9,
  parameter int DEPTH      = 64,
  parameter int IDLE_TICKS = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic              rd_stb,
  input logic              irq_en,
  input logic [CNT_W-1:0]  threshold,
  input logic              err_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  count,
  input logic              full_flag,
  input logic              ovr_flag,
  input logic              irq,
  input logic              idle_hit
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= CAP);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + ONE) ||
    (count == $past(count) - ONE));

  assert_threshold_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (threshold != '0 && count == threshold && !(rd_stb && count == ONE && !word_valid))
    |=> full_flag);

  assert_idle_sets_full_R4: assert property (@(posedge clk) disable iff (rst)
    idle_hit |=> full_flag);

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (full_flag && !(rd_stb && count == ONE && !word_valid)) |=> full_flag);

  assert_full_drains_R7: assert property (@(posedge clk) disable iff (rst)
    (full_flag && rd_stb && count == ONE && !word_valid) |=> (!full_flag && count == '0));

  assert_overrun_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (word_valid && count == CAP && !rd_stb) |=> (ovr_flag && count == CAP));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !err_clr) |=> ovr_flag);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && (full_flag || ovr_flag)));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && count == '0 && !word_valid) |=> (count == '0 && $stable(rd_data)));
endmodule

bind rx_fifo_irq_ctrl rx_fifo_irq_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .IDLE_TICKS(IDLE_TICKS)
) u_chk (.*);

// File: tb/rx_fifo_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rx_fifo_irq_ctrl_bench;
  localparam int DW    = 9;
  localparam int DEP   = 8;
  localparam int IDLE  = 3;
  localparam int CW    = $clog2(DEP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 0, rd_stb = 0, fifo_en = 0, idle_en = 0, irq_en = 0;
  logic baud_tick = 0, err_clr = 0;
  logic [DW-1:0] word_data = '0;
  logic [CW-1:0] threshold = '0;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] count;
  logic full_flag, ovr_flag, irq;

  always #5 clk = ~clk;

  rx_fifo_irq_ctrl #(.DATA_W(DW), .DEPTH(DEP), .IDLE_TICKS(IDLE)) u_rx_fifo_irq_ctrl (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .rd_stb(rd_stb), .fifo_en(fifo_en), .idle_en(idle_en), .irq_en(irq_en),
    .threshold(threshold), .baud_tick(baud_tick), .err_clr(err_clr),
    .rd_data(rd_data), .count(count), .full_flag(full_flag),
    .ovr_flag(ovr_flag), .irq(irq));

  // expected state, built from the requirements
  logic [DW-1:0] q[$];
  logic [DW-1:0] e_rd = '0;
  logic e_full = 0, e_ovr = 0, e_irq = 0;
  int   e_idle = 0;
  int   vectors = 0, fails = 0;
  bit   done = 0;
  string phase = "R12";

  function automatic bit idle_armed(int n, bit full);
    return idle_en && fifo_en && n != 0 && !full &&
           (threshold == 0 || n < int'(threshold));
  endfunction

  task automatic chk(string tag, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic step(bit wv, logic [DW-1:0] d, bit rd, bit tk, bit ec);
    int  n;
    bit  push, pop, ovr_hit, drained, thr_hit, hit, armed;
    @(negedge clk);
    word_valid = wv; word_data = d; rd_stb = rd; baud_tick = tk; err_clr = ec;
    n       = q.size();
    push    = wv && n != DEP;
    pop     = rd && n != 0;
    ovr_hit = wv && n == DEP;
    drained = pop && !push && n == 1;
    thr_hit = threshold != 0 && n == int'(threshold);
    armed   = idle_armed(n, e_full);
    hit     = armed && !wv && !rd && tk && e_idle == IDLE;
    if (!armed || wv || rd) e_idle = 0;
    else if (tk)            e_idle = (e_idle == IDLE) ? 0 : e_idle + 1;
    if (pop)  e_rd = q.pop_front();
    if (push) q.push_back(d);
    e_full = drained ? 1'b0 : (e_full | thr_hit | hit);
    e_ovr  = ovr_hit ? 1'b1 : (ec ? 1'b0 : e_ovr);
    e_irq  = irq_en && (e_full || e_ovr);
    @(posedge clk);
    #1;
    vectors++;
    chk("R1/R2/R8/R11 count", int'(count), q.size());
    chk("R1/R8/R11 rd_data", int'(rd_data), int'(e_rd));
    chk("R3/R4/R5/R6/R7 full_flag", int'(full_flag), int'(e_full));
    chk("R8/R9 ovr_flag", int'(ovr_flag), int'(e_ovr));
    chk("R10 irq", int'(irq), int'(e_irq));
  endtask

  task automatic idle_cycles(int k);
    for (int i = 0; i < k; i++) step(0, '0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12: reset state
    #1;
    vectors++;
    chk("R12 count", int'(count), 0);
    chk("R12 rd_data", int'(rd_data), 0);
    chk("R12 full_flag", int'(full_flag), 0);
    chk("R12 ovr_flag", int'(ovr_flag), 0);
    chk("R12 irq", int'(irq), 0);

    // R1, R3, R7: threshold of 4, fill then drain
    phase = "R3"; threshold = 4; irq_en = 1; fifo_en = 1;
    for (int i = 0; i < 4; i++) step(1, DW'(9'h101 + i), 0, 0, 0);
    idle_cycles(2);
    phase = "R7";
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0);
    idle_cycles(1);

    // R11: read of empty buffer
    phase = "R11";
    step(0, '0, 1, 0, 0);
    step(0, '0, 1, 1, 0);

    // R2: simultaneous arrival and read
    phase = "R2"; threshold = 0;
    step(1, 9'h0aa, 0, 0, 0);
    step(1, 9'h0bb, 1, 0, 0);
    step(1, 9'h0cc, 1, 0, 0);
    step(0, '0, 1, 0, 0);

    // R4: idle timeout with 1 word and threshold 6
    phase = "R4"; threshold = 6; idle_en = 1;
    step(1, 9'h011, 0, 0, 0);
    for (int i = 0; i < IDLE + 1; i++) begin step(0, '0, 0, 1, 0); step(0, '0, 0, 0, 0); end
    step(0, '0, 1, 0, 0);
    // R5: read in the middle of the count restarts it
    phase = "R5";
    step(1, 9'h012, 0, 0, 0);
    step(1, 9'h013, 0, 0, 0);
    for (int i = 0; i < IDLE; i++) step(0, '0, 0, 1, 0);
    step(0, '0, 1, 0, 0);
    for (int i = 0; i < IDLE; i++) step(0, '0, 0, 1, 0);
    step(0, '0, 0, 1, 0);
    // R6: disable holds count at zero, re-enable restarts
    phase = "R6";
    step(0, '0, 1, 0, 0); step(0, '0, 1, 0, 0);
    step(1, 9'h014, 0, 0, 0);
    for (int i = 0; i < IDLE; i++) step(0, '0, 0, 1, 0);
    fifo_en = 0; step(0, '0, 0, 1, 0);
    fifo_en = 1;
    for (int i = 0; i < IDLE; i++) step(0, '0, 0, 1, 0);
    step(0, '0, 0, 1, 0);
    step(0, '0, 1, 0, 0);

    // R8, R9: overrun at capacity, discard, sticky, clear
    phase = "R8"; idle_en = 0; threshold = 0;
    for (int i = 0; i < DEP; i++) step(1, DW'(9'h040 + i), 0, 0, 0);
    step(1, 9'h1ff, 0, 0, 0);
    step(1, 9'h1fe, 1, 0, 0);
    idle_cycles(2);
    phase = "R9";
    step(0, '0, 0, 0, 1);
    step(1, 9'h1fd, 0, 0, 1);
    step(0, '0, 0, 0, 0);
    phase = "R10"; irq_en = 0; step(0, '0, 0, 0, 0);
    irq_en = 1; step(0, '0, 0, 0, 1);
    for (int i = 0; i < DEP; i++) step(0, '0, 1, 0, 0);

    // random mix
    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) threshold = CW'($urandom % (DEP + 1));
      if (($urandom % 40) == 0) fifo_en  = $urandom % 4 != 0;
      if (($urandom % 40) == 0) idle_en  = $urandom % 4 != 0;
      if (($urandom % 30) == 0) irq_en   = $urandom % 3 != 0;
      step(($urandom % 3) == 0, DW'($urandom), ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 25) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule